// File: doc/BRIEF.md
# Timed Configuration Fuse and Lock Readback Controller

This block is the part of a self-programming control path that lets firmware read back the device's configuration fuse byte and its lock bits. The CPU writes a small control register with a read-configuration bit and a self-program enable bit. Writing both bits together arms the block. A program-memory load that follows within a few cycles returns a configuration byte instead of flash data. The load's Z address picks which byte comes back.

Arming only lasts a short time. The bits clear themselves once a readback completes, once a store arrives, or once the load or store window runs out. While an EEPROM write is busy, the control register refuses writes, so no readback can start. The fuse and lock states come in as static ports, with 1 meaning programmed. The block returns them with inverted polarity, so a programmed bit reads as 0.

Top module: `cfgrd_unit`

## Requirements
- R1: A synchronous active-high reset clears both control bits, clears the cycle counter and drops `ld_valid`. After reset, loads return flash data.
- R2: The block is armed only when a single accepted control write sets both `wr_rdcfg` and `wr_spen`. A write that sets only one of them leaves loads returning `flash_data`.
- R3: A load with `ld_addr` = 0x0000 while armed returns the bitwise inverse of `fuse_prog` on `ld_data`. `ld_valid` is high in the cycle after the load strobe.
- R4: A load with `ld_addr` = 0x0001 while armed returns a byte whose bits 1..0 are the inverse of `lock_prog[1:0]` (bit 0 = first lock bit, bit 1 = second) and whose bits 7..2 are 1.
- R5: The cycle right after the accepted control write is cycle 1. A load in cycles 1, 2 or 3 is served from the configuration bytes. The arming bits are clear from cycle 4 on, so a load in cycle 4 returns flash data.
- R6: A load or a store while armed clears both control bits in the following cycle. `ld_valid` stays high for one cycle only.
- R7: With only `wr_spen` set, the enable bit clears after cycle 4 if no store arrives. A store in the window clears it in the next cycle.
- R8: While `ee_busy` is high, control writes are ignored: the control bits keep their previous values and a following load returns flash data.
- R9: Loads while not armed return `flash_data`, captured on the strobe cycle. A load at any address other than 0x0000 or 0x0001 while armed also returns `flash_data`, and it disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| wr_rdcfg | input | 1 | Read-configuration bit value for the write |
| wr_spen | input | 1 | Self-program enable bit value for the write |
| ee_busy | input | 1 | EEPROM write in progress; blocks control writes |
| ld_stb | input | 1 | Program-memory load strobe |
| ld_addr | input | 16 | Z address of the load |
| st_stb | input | 1 | Program-memory store strobe |
| flash_data | input | 8 | Flash byte at `ld_addr` |
| fuse_prog | input | 8 | Fuse low byte, 1 = programmed |
| lock_prog | input | 2 | Lock bits, 1 = programmed |
| ld_data | output | 8 | Load result, registered |
| ld_valid | output | 1 | High for the cycle after a load strobe |
| ctl_rdcfg | output | 1 | Current read-configuration bit |
| ctl_spen | output | 1 | Current self-program enable bit |

## Verification
The assertions assume that `fuse_prog` and `lock_prog` stay static, that `ld_stb`, `st_stb` and `ctl_wr` are single-cycle pulses, and that no input carries X after reset. The bench changes inputs only on falling edges. It holds the fuse and lock ports constant for the whole run and pulses each strobe for exactly one cycle. `flash_data` is derived from `ld_addr` in a way that differs from both configuration images, so a wrong source selection shows up in the data.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int LOCK_W    = 2;
    localparam int LOAD_WIN  = 3;
    localparam int STORE_WIN = 4;
    localparam logic [ADDR_W-1:0] FUSE_ZADDR = 16'h0000;
    localparam logic [ADDR_W-1:0] LOCK_ZADDR = 16'h0001;

    typedef enum logic [1:0] {
        SRC_FLASH = 2'd0,
        SRC_FUSE  = 2'd1,
        SRC_LOCK  = 2'd2
    } src_e;

    typedef struct packed {
        logic rdcfg;
        logic spen;
    } ctl_t;

    // programmed = 1 on the inputs, reads back as 0
    function automatic logic [DATA_W-1:0] fuse_image(input logic [DATA_W-1:0] prog);
        return ~prog;
    endfunction

    function automatic logic [DATA_W-1:0] lock_image(input logic [LOCK_W-1:0] prog);
        logic [DATA_W-1:0] img;
        img = '1;
        img[LOCK_W-1:0] = ~prog;
        return img;
    endfunction

    function automatic src_e pick_src(input logic armed, input logic [ADDR_W-1:0] addr);
        if (!armed)                return SRC_FLASH;
        else if (addr == FUSE_ZADDR) return SRC_FUSE;
        else if (addr == LOCK_ZADDR) return SRC_LOCK;
        else                       return SRC_FLASH;
    endfunction
endpackage

// File: rtl/cfgrd_ctl.sv
module cfgrd_ctl
    import cfgrd_pkg::*;
#(
    parameter int LD_WIN = LOAD_WIN,
    parameter int ST_WIN = STORE_WIN
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic ee_busy,
    input  ctl_t wr_val,
    input  logic ld_stb,
    input  logic st_stb,
    output ctl_t ctl_q,
    output logic armed
);
    localparam int AGE_W = $clog2(ST_WIN + 2);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] age_q;
    logic             wr_ok;
    logic             drop;

    assign wr_ok = ctl_wr & ~ee_busy;
    assign armed = ctl_q.rdcfg & ctl_q.spen;

    always_comb begin
        drop = 1'b0;
        if (armed)
            drop = ld_stb | st_stb | (age_q >= AGE_W'(LD_WIN));
        else if (ctl_q.spen)
            drop = st_stb | (age_q >= AGE_W'(ST_WIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            age_q <= '0;
        end else if (wr_ok) begin
            ctl_q <= wr_val;
            age_q <= AGE_W'(1);
        end else begin
            if (drop)
                ctl_q <= '0;
            if (ctl_q.spen && age_q != AGE_MAX)
                age_q <= age_q + AGE_W'(1);
        end
    end
endmodule

// File: rtl/cfgrd_rdmux.sv
module cfgrd_rdmux
    import cfgrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_stb,
    input  logic              armed,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] flash_data,
    input  logic [DATA_W-1:0] fuse_prog,
    input  logic [LOCK_W-1:0] lock_prog,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_valid
);
    src_e              src;
    logic [DATA_W-1:0] pick;

    assign src = pick_src(armed, ld_addr);

    always_comb begin
        case (src)
            SRC_FUSE: pick = fuse_image(fuse_prog);
            SRC_LOCK: pick = lock_image(lock_prog);
            default:  pick = flash_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_data  <= '0;
            ld_valid <= 1'b0;
        end else begin
            ld_valid <= ld_stb;
            if (ld_stb)
                ld_data <= pick;
        end
    end
endmodule

// File: rtl/cfgrd_unit.sv
module cfgrd_unit
    import cfgrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              wr_rdcfg,
    input  logic              wr_spen,
    input  logic              ee_busy,
    input  logic              ld_stb,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_stb,
    input  logic [DATA_W-1:0] flash_data,
    input  logic [DATA_W-1:0] fuse_prog,
    input  logic [LOCK_W-1:0] lock_prog,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_valid,
    output logic              ctl_rdcfg,
    output logic              ctl_spen
);
    ctl_t wr_val;
    ctl_t ctl_q;
    logic armed;

    assign wr_val.rdcfg = wr_rdcfg;
    assign wr_val.spen  = wr_spen;
    assign ctl_rdcfg    = ctl_q.rdcfg;
    assign ctl_spen     = ctl_q.spen;

    cfgrd_ctl #(.LD_WIN(LOAD_WIN), .ST_WIN(STORE_WIN)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .ctl_wr (ctl_wr),
        .ee_busy(ee_busy),
        .wr_val (wr_val),
        .ld_stb (ld_stb),
        .st_stb (st_stb),
        .ctl_q  (ctl_q),
        .armed  (armed)
    );

    cfgrd_rdmux u_mux (
        .clk       (clk),
        .rst       (rst),
        .ld_stb    (ld_stb),
        .armed     (armed),
        .ld_addr   (ld_addr),
        .flash_data(flash_data),
        .fuse_prog (fuse_prog),
        .lock_prog (lock_prog),
        .ld_data   (ld_data),
        .ld_valid  (ld_valid)
    );
endmodule

// File: rtl/cfgrd_unit_chk.sv
module cfgrd_unit_chk
    import cfgrd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctl_wr,
    input logic              ee_busy,
    input logic              ld_stb,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              st_stb,
    input logic [DATA_W-1:0] flash_data,
    input logic [DATA_W-1:0] fuse_prog,
    input logic [LOCK_W-1:0] lock_prog,
    input logic [DATA_W-1:0] ld_data,
    input logic              ld_valid,
    input logic              ctl_rdcfg,
    input logic              ctl_spen
);
    logic [2:0] since_wr;

    always_ff @(posedge clk) begin
        if (rst)
            since_wr <= 3'd7;
        else if (ctl_wr && !ee_busy)
            since_wr <= 3'd1;
        else if (since_wr != 3'd7)
            since_wr <= since_wr + 3'd1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (!ctl_rdcfg && !ctl_spen && !ld_valid));

    // R5
    load_window_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdcfg && ctl_spen) |-> (since_wr <= 3'd3));

    // R7
    store_window_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_spen |-> (since_wr <= 3'd4));

    // R8
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_rdcfg && !ctl_spen && !(ctl_wr && !ee_busy)) |=> (!ctl_rdcfg && !ctl_spen));

    // R6
    consume_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        ((ld_stb || st_stb) && ctl_rdcfg && ctl_spen && !ctl_wr) |=> (!ctl_rdcfg && !ctl_spen));

    // R3
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ld_stb |=> ld_valid);

    // R3
    fuse_data_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && ctl_rdcfg && ctl_spen && ld_addr == 16'h0000) |=> (ld_data == ~$past(fuse_prog)));

    // R4
    lock_data_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && ctl_rdcfg && ctl_spen && ld_addr == 16'h0001) |=>
            (ld_data[1:0] == ~$past(lock_prog) && ld_data[7:2] == 6'h3f));

    // R9
    flash_data_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && !(ctl_rdcfg && ctl_spen)) |=> (ld_data == $past(flash_data)));
endmodule

bind cfgrd_unit cfgrd_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ee_busy   (ee_busy),
    .ld_stb    (ld_stb),
    .ld_addr   (ld_addr),
    .st_stb    (st_stb),
    .flash_data(flash_data),
    .fuse_prog (fuse_prog),
    .lock_prog (lock_prog),
    .ld_data   (ld_data),
    .ld_valid  (ld_valid),
    .ctl_rdcfg (ctl_rdcfg),
    .ctl_spen  (ctl_spen)
);

// File: tb/cfgrd_unit_test.sv
module cfgrd_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic        rd;
        logic        sp;
        logic [2:0]  dly;
        logic [15:0] addr;
        logic [7:0]  expv;
    } vec_t;

    // fuse_prog = 8'hA6 reads 8'h59; lock_prog = 2'b01 reads 8'hFE; flash = addr[7:0] ^ 8'h5A
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 3'd1, 16'h0000, 8'h59},  // R3
        {1'b1, 1'b1, 3'd2, 16'h0001, 8'hFE},  // R4
        {1'b1, 1'b1, 3'd3, 16'h0000, 8'h59},  // R5 last accepted cycle
        {1'b1, 1'b1, 3'd4, 16'h0000, 8'h5A},  // R5 too late
        {1'b1, 1'b0, 3'd1, 16'h0000, 8'h5A},  // R2 read bit alone
        {1'b0, 1'b1, 3'd1, 16'h0001, 8'h5B},  // R2 enable bit alone
        {1'b1, 1'b1, 3'd1, 16'h0002, 8'h58},  // R9 other address
        {1'b1, 1'b1, 3'd3, 16'h0001, 8'hFE}   // R4 late in window
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0, wr_rdcfg = 1'b0, wr_spen = 1'b0, ee_busy = 1'b0;
    logic        ld_stb = 1'b0, st_stb = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  flash_data;
    logic [7:0]  fuse_prog = 8'hA6;
    logic [1:0]  lock_prog = 2'b01;
    logic [7:0]  ld_data;
    logic        ld_valid, ctl_rdcfg, ctl_spen;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign flash_data = ld_addr[7:0] ^ 8'h5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgrd_unit uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wr_rdcfg(wr_rdcfg), .wr_spen(wr_spen),
        .ee_busy(ee_busy), .ld_stb(ld_stb), .ld_addr(ld_addr), .st_stb(st_stb),
        .flash_data(flash_data), .fuse_prog(fuse_prog), .lock_prog(lock_prog),
        .ld_data(ld_data), .ld_valid(ld_valid), .ctl_rdcfg(ctl_rdcfg), .ctl_spen(ctl_spen)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // leaves the bench at the falling edge inside cycle 1
    task automatic ctl_write(input logic rd, input logic sp);
        ctl_wr = 1'b1; wr_rdcfg = rd; wr_spen = sp;
        tick();
        ctl_wr = 1'b0; wr_rdcfg = 1'b0; wr_spen = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] a);
        ld_stb = 1'b1; ld_addr = a;
        tick();
        ld_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 rdcfg after reset", {7'd0, ctl_rdcfg}, 8'h00);
        check("R1 spen after reset", {7'd0, ctl_spen}, 8'h00);
        check("R1 valid after reset", {7'd0, ld_valid}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = vec_t'(VEC[i]);
            ctl_write(v.rd, v.sp);
            repeat (int'(v.dly) - 1) tick();
            do_load(v.addr);
            check($sformatf("table %0d data", i), ld_data, v.expv);
            check($sformatf("table %0d valid R3", i), {7'd0, ld_valid}, 8'h01);
            if (v.rd && v.sp)
                check($sformatf("table %0d disarmed R6", i), {6'd0, ctl_rdcfg, ctl_spen}, 8'h00);
            tick();
            // R6 valid is a single-cycle pulse
            check($sformatf("table %0d valid drop R6", i), {7'd0, ld_valid}, 8'h00);
            repeat (6) tick();
        end

        // R5 armed bits hold through cycle 3, clear in cycle 4
        ctl_write(1'b1, 1'b1);
        repeat (2) tick();
        check("R5 armed in cycle 3", {6'd0, ctl_rdcfg, ctl_spen}, 8'h03);
        tick();
        check("R5 cleared in cycle 4", {6'd0, ctl_rdcfg, ctl_spen}, 8'h00);
        repeat (4) tick();

        // R7 enable alone lasts through cycle 4
        ctl_write(1'b0, 1'b1);
        repeat (3) tick();
        check("R7 spen in cycle 4", {7'd0, ctl_spen}, 8'h01);
        tick();
        check("R7 spen cleared in cycle 5", {7'd0, ctl_spen}, 8'h00);
        repeat (2) tick();

        // R7 store consumes the enable
        ctl_write(1'b0, 1'b1);
        tick();
        st_stb = 1'b1;
        tick();
        st_stb = 1'b0;
        check("R7 store clears spen", {7'd0, ctl_spen}, 8'h00);
        repeat (2) tick();

        // R6 store while armed disarms
        ctl_write(1'b1, 1'b1);
        st_stb = 1'b1;
        tick();
        st_stb = 1'b0;
        check("R6 store disarms", {6'd0, ctl_rdcfg, ctl_spen}, 8'h00);
        repeat (2) tick();

        // R8 busy EEPROM blocks the control write
        ee_busy = 1'b1;
        ctl_write(1'b1, 1'b1);
        check("R8 bits stay clear", {6'd0, ctl_rdcfg, ctl_spen}, 8'h00);
        do_load(16'h0000);
        check("R8 load returns flash", ld_data, 8'h5A);
        ee_busy = 1'b0;
        repeat (2) tick();

        // R9 load with nothing armed
        do_load(16'h0001);
        check("R9 unarmed load", ld_data, 8'h5B);
        tick();

        // R1 reset while armed
        ctl_write(1'b1, 1'b1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 reset disarms", {6'd0, ctl_rdcfg, ctl_spen}, 8'h00);
        do_load(16'h0000);
        check("R1 load after reset is flash", ld_data, 8'h5A);
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule